// File: doc/BRIEF.md
# Triggered Signal Trace Capture Unit

This unit watches one signed 16-bit sample stream and records a window of that stream into an internal buffer once a trigger condition is met. A host programs a trigger mode, a trigger value and a capture depth, then pulses a start command. The unit arms, compares each valid sample against the trigger value and, on the first matching sample, stores that sample and the samples that follow it until the programmed depth is reached. A stop command aborts the trace at any moment.

There are five trigger modes. One fires on the first valid sample. One fires on an exact match. Three fire on a threshold crossing: upward, downward, or in either direction. After the capture completes, the host reads the buffer through an address/data port with one cycle of read latency.

Top module: `trace_capture`

## Requirements
- R1: After reset `busy` and `done` are 0 and `count` is 0.
- R2: A start command with a mode code from 0 to 4 arms the unit on the next cycle (`busy`=1, `done`=0, `count`=0). The mode and depth are latched at start, and later changes to `cfg_mode` and `cfg_depth` have no effect on the running trace.
- R3: Mode 0 (always) triggers on the first valid sample after start.
- R4: Mode 1 (level) triggers on a valid sample whose signed value equals `cfg_level`.
- R5: Mode 2 (rising) triggers when the previous valid sample is strictly below `cfg_level` and the current one is strictly above it. Both comparisons are signed. The first valid sample after start never triggers an edge mode.
- R6: Mode 3 (falling) triggers when the previous valid sample is strictly above `cfg_level` and the current one is strictly below it. The same signed and first-sample rules apply as in R5.
- R7: Mode 4 (either) triggers on any crossing that satisfies R5 or R6.
- R8: `cfg_level` is not latched. A new value applies from the next sample comparison.
- R9: The triggering sample is stored at buffer entry 0, and each later valid sample goes to the next entry. Cycles without `smp_valid` store nothing. `count` equals the number of entries stored.
- R10: The effective depth is `cfg_depth` clamped to the range 1 to MAX_DEPTH (4096). When `count` reaches that depth, `done`=1 and `busy`=0. Nothing more is written, and `count` holds, until the next start.
- R11: A stop command returns the unit to idle on the next cycle (`busy`=0, `done`=0). `count` holds and no further entries are written. Stop takes priority over a start in the same cycle.
- R12: A start command with mode code 5, 6 or 7 acts as a stop. The unit stays idle and `count` is unchanged.
- R13: `rd_data` shows the buffer entry at the `rd_addr` value sampled on the previous clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | Sample strobe |
| smp_data | input | 16 | Signed sample value |
| cfg_mode | input | 3 | Trigger mode: 0 always, 1 level, 2 rising, 3 falling, 4 either |
| cfg_level | input | 16 | Signed trigger value |
| cfg_depth | input | 13 | Requested capture depth |
| cmd_start | input | 1 | Start (arm) pulse |
| cmd_stop | input | 1 | Abort pulse |
| busy | output | 1 | Armed or capturing |
| done | output | 1 | Capture complete |
| count | output | 13 | Entries stored in the current trace |
| rd_addr | input | 12 | Buffer read address |
| rd_data | output | 16 | Buffer read data, one cycle after the address |

## Verification
Every cycle, the assertions check the command behaviour and the counter invariants. These cover arming on start, idling on stop or on an invalid mode, `count` advancing by at most one and only with a valid sample, `done` and `count` holding after completion, and `busy` and `done` never being high together. Some behaviour only the bench scenarios can show, because it depends on the data: which sample fires each trigger mode, the contents of the stored window, a level change taking effect mid-trace, and the depth clamp at both ends. The bench checks these against a reference model of the requirements, using random streams around the trigger value and directed corner cases.

// File: rtl/trace_capture.sv
module trace_capture #(
  parameter int DW = 16,
  parameter int MAX_DEPTH = 4096,
  localparam int AW = $clog2(MAX_DEPTH),
  localparam int CW = AW + 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 smp_valid,
  input  logic signed [DW-1:0] smp_data,
  input  logic [2:0]           cfg_mode,
  input  logic signed [DW-1:0] cfg_level,
  input  logic [CW-1:0]        cfg_depth,
  input  logic                 cmd_start,
  input  logic                 cmd_stop,
  output logic                 busy,
  output logic                 done,
  output logic [CW-1:0]        count,
  input  logic [AW-1:0]        rd_addr,
  output logic signed [DW-1:0] rd_data
);

  typedef enum logic [1:0] {S_IDLE, S_ARM, S_CAP, S_DONE} state_t;

  state_t               st;
  logic [2:0]           mode_q;
  logic [CW-1:0]        depth_q;
  logic [CW-1:0]        cnt_q;
  logic signed [DW-1:0] prev_q;
  logic                 have_prev;
  logic signed [DW-1:0] mem [MAX_DEPTH];

  wire mode_ok = (cfg_mode <= 3'd4);

  wire [CW-1:0] depth_eff = (cfg_depth == '0) ? CW'(1) :
                            (cfg_depth > CW'(MAX_DEPTH)) ? CW'(MAX_DEPTH) : cfg_depth;

  wire cur_above  = smp_data > cfg_level;
  wire cur_below  = smp_data < cfg_level;
  wire prev_above = prev_q > cfg_level;
  wire prev_below = prev_q < cfg_level;
  wire rise       = have_prev && prev_below && cur_above;
  wire fall       = have_prev && prev_above && cur_below;

  logic fire;
  always_comb begin
    case (mode_q)
      3'd0:    fire = 1'b1;
      3'd1:    fire = (smp_data == cfg_level);
      3'd2:    fire = rise;
      3'd3:    fire = fall;
      3'd4:    fire = rise | fall;
      default: fire = 1'b0;
    endcase
  end

  wire take_first = (st == S_ARM) && smp_valid && fire;
  wire take_next  = (st == S_CAP) && smp_valid;
  wire ctl_quiet  = !cmd_stop && !cmd_start;
  wire wr_en      = ctl_quiet && (take_first || take_next);
  wire [AW-1:0] wr_addr = take_first ? '0 : cnt_q[AW-1:0];
  wire [CW-1:0] cnt_nxt = cnt_q + CW'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      mode_q    <= '0;
      depth_q   <= CW'(1);
      cnt_q     <= '0;
      prev_q    <= '0;
      have_prev <= 1'b0;
    end else if (cmd_stop) begin
      st <= S_IDLE;
    end else if (cmd_start) begin
      if (mode_ok) begin
        st        <= S_ARM;
        mode_q    <= cfg_mode;
        depth_q   <= depth_eff;
        cnt_q     <= '0;
        have_prev <= 1'b0;
      end else begin
        st <= S_IDLE;
      end
    end else begin
      case (st)
        S_ARM: if (smp_valid) begin
          prev_q    <= smp_data;
          have_prev <= 1'b1;
          if (fire) begin
            cnt_q <= CW'(1);
            st    <= (depth_q == CW'(1)) ? S_DONE : S_CAP;
          end
        end
        S_CAP: if (smp_valid) begin
          cnt_q <= cnt_nxt;
          if (cnt_nxt == depth_q) st <= S_DONE;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= smp_data;
    rd_data <= mem[rd_addr];
  end

  assign busy  = (st == S_ARM) || (st == S_CAP);
  assign done  = (st == S_DONE);
  assign count = cnt_q;

endmodule

// File: rtl/trace_capture_chk.sv
module trace_capture_chk #(
  parameter int CW = 13,
  parameter int MAX_DEPTH = 4096
) (
  input logic          clk,
  input logic          rst_n,
  input logic          smp_valid,
  input logic [2:0]    cfg_mode,
  input logic          cmd_start,
  input logic          cmd_stop,
  input logic          busy,
  input logic          done,
  input logic [CW-1:0] count
);

  AST_START_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_start && !cmd_stop && (cfg_mode <= 3'd4) |=> busy && !done && (count == '0)); // R2

  AST_NOVALID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_valid && !cmd_start && !cmd_stop |=> $stable(count) && $stable(done)); // R9

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !cmd_start && !cmd_stop |=> (count == $past(count)) || (count == $past(count) + CW'(1))); // R9

  AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    done && !cmd_start && !cmd_stop |=> done && $stable(count)); // R10

  AST_BUSY_DONE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done)); // R10

  AST_COUNT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(MAX_DEPTH)); // R10

  AST_STOP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_stop |=> !busy && !done && $stable(count)); // R11

  AST_BAD_MODE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_start && (cfg_mode > 3'd4) |=> !busy && !done && $stable(count)); // R12

endmodule

bind trace_capture trace_capture_chk #(.CW(CW), .MAX_DEPTH(MAX_DEPTH)) i_chk (
  .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .cfg_mode(cfg_mode),
  .cmd_start(cmd_start), .cmd_stop(cmd_stop), .busy(busy), .done(done), .count(count)
);

// File: tb/test_trace_capture.sv
`timescale 1ns/1ps
module test_trace_capture;
  localparam int MAXD = 4096;

  logic clk = 0, rst_n = 0;
  logic smp_valid = 0;
  logic signed [15:0] smp_data = 0;
  logic [2:0] cfg_mode = 0;
  logic signed [15:0] cfg_level = 0;
  logic [12:0] cfg_depth = 1;
  logic cmd_start = 0, cmd_stop = 0;
  logic busy, done;
  logic [12:0] count;
  logic [11:0] rd_addr = 0;
  logic signed [15:0] rd_data;

  int checks = 0, fails = 0;
  int svals[256];
  bit svld[256];
  int slvl[256];
  int exp_buf[MAXD];
  int exp_cnt;
  bit exp_busy, exp_done;

  always #2.5 clk = ~clk;

  trace_capture i_trace_capture (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
    .cfg_mode(cfg_mode), .cfg_level(cfg_level), .cfg_depth(cfg_depth),
    .cmd_start(cmd_start), .cmd_stop(cmd_stop), .busy(busy), .done(done),
    .count(count), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  initial begin
    #750000;
    fails++;
    $display("FAIL watchdog: run did not finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic put(input int v);
    smp_data = 16'(v); smp_valid = 1;
    @(negedge clk);
    smp_valid = 0;
  endtask

  task automatic do_start(input int m, input int lvl, input int d);
    cfg_mode = 3'(m); cfg_level = 16'(lvl); cfg_depth = 13'(d);
    cmd_start = 1;
    @(negedge clk);
    cmd_start = 0;
  endtask

  task automatic rd(input int a, output int v);
    rd_addr = 12'(a);
    @(negedge clk);
    v = int'(rd_data);
  endtask

  task automatic buf_chk(input string req, input int n);
    int errs = 0, bad_i = 0, bad_a = 0, bad_e = 0;
    for (int i = 0; i < n; i++) begin
      int v;
      rd(i, v);
      if (v != exp_buf[i] && errs++ == 0) begin bad_i = i; bad_a = v; bad_e = exp_buf[i]; end
    end
    checks++;
    if (errs != 0) begin
      fails++;
      $display("FAIL %s: entry %0d actual %0d expected %0d", req, bad_i, bad_a, bad_e);
    end
  endtask

  function automatic int clampd(input int d);
    return (d == 0) ? 1 : (d > MAXD ? MAXD : d);
  endfunction

  function automatic void model(input int mode, input int d, input int n);
    int st = 1, cnt = 0, prev = 0, dep = clampd(d);
    bit hp = 0;
    for (int i = 0; i < n; i++) begin
      if (!svld[i]) continue;
      if (st == 1) begin
        bit r = hp && prev < slvl[i] && svals[i] > slvl[i];
        bit f = hp && prev > slvl[i] && svals[i] < slvl[i];
        bit fire = (mode == 0) || (mode == 1 && svals[i] == slvl[i]) ||
                   (mode == 2 && r) || (mode == 3 && f) || (mode == 4 && (r || f));
        prev = svals[i]; hp = 1;
        if (fire) begin
          exp_buf[0] = svals[i]; cnt = 1;
          st = (cnt == dep) ? 3 : 2;
        end
      end else if (st == 2) begin
        exp_buf[cnt] = svals[i]; cnt++;
        if (cnt == dep) st = 3;
      end
    end
    exp_cnt = cnt; exp_busy = (st == 1 || st == 2); exp_done = (st == 3);
  endfunction

  task automatic run_scn(input int mode, input int d, input int n, input string tg);
    do_start(mode, slvl[0], d);
    for (int i = 0; i < n; i++) begin
      cfg_level = 16'(slvl[i]); smp_data = 16'(svals[i]); smp_valid = svld[i];
      @(negedge clk);
    end
    smp_valid = 0;
    model(mode, d, n);
    chk({tg, " count R9"}, int'(count), exp_cnt);
    chk({tg, " busy"}, int'(busy), int'(exp_busy));
    chk({tg, " done R10"}, int'(done), int'(exp_done));
    buf_chk({tg, " buffer R9 R8"}, exp_cnt);
  endtask

  initial begin
    int v, v2, lvl;
    process::self().srandom(32'd1234);
    repeat (3) @(negedge clk);
    chk("R1 busy", int'(busy), 0);
    chk("R1 done", int'(done), 0);
    chk("R1 count", int'(count), 0);
    rst_n = 1;
    @(negedge clk);

    // R2: mode and depth latched at start
    do_start(1, 50, 3);
    chk("R2 busy after start", int'(busy), 1);
    cfg_mode = 0; cfg_depth = 1;
    put(1);
    chk("R2 mode latched", int'(count), 0);
    put(50);
    chk("R4 level fire", int'(count), 1);
    chk("R2 depth latched", int'(busy), 1);

    // R5: first sample ignored, equal value is not a crossing
    put(-10);
    do_start(2, 0, 2);
    put(5);
    chk("R5 first sample ignored", int'(count), 0);
    put(-3); put(0); put(3);
    chk("R5 touching level is no crossing", int'(count), 0);
    put(-2); put(4);
    chk("R5 rising fire", int'(count), 1);
    put(9);
    chk("R10 done at depth", int'(done), 1);
    exp_buf[0] = 4; exp_buf[1] = 9;
    buf_chk("R5 buffer", 2);

    // R8: level change applies on next comparison
    do_start(1, 100, 4);
    put(7);
    chk("R8 no match", int'(count), 0);
    cfg_level = 7;
    put(7);
    chk("R8 new level used", int'(count), 1);

    // R11: stop aborts
    do_start(0, 0, 20);
    repeat (5) put(3);
    cmd_stop = 1; @(negedge clk); cmd_stop = 0;
    repeat (3) put(4);
    chk("R11 busy", int'(busy), 0);
    chk("R11 done", int'(done), 0);
    chk("R11 count holds", int'(count), 5);
    cmd_stop = 1; do_start(0, 0, 5); cmd_stop = 0;
    chk("R11 stop beats start", int'(busy), 0);

    // R12: invalid mode
    do_start(0, 0, 10);
    put(1); put(2);
    do_start(6, 0, 10);
    repeat (3) put(5);
    chk("R12 busy", int'(busy), 0);
    chk("R12 done", int'(done), 0);
    chk("R12 count", int'(count), 2);

    // R10: depth clamp high
    do_start(0, 0, 5000);
    for (int i = 0; i < 4100; i++) put(i);
    chk("R10 max count", int'(count), MAXD);
    chk("R10 max done", int'(done), 1);
    rd(0, v);    chk("R10 first entry", v, 0);
    rd(4095, v); chk("R10 last entry", v, 4095);

    // R13: one-cycle read latency
    rd(10, v);
    rd_addr = 11; #1;
    chk("R13 data before edge", int'(rd_data), 10);
    @(negedge clk);
    chk("R13 data after edge", int'(rd_data), 11);

    // R10: depth 0 acts as 1, done holds
    do_start(0, 0, 0);
    put(77); put(78); put(79);
    chk("R10 depth zero count", int'(count), 1);
    chk("R10 done holds", int'(done), 1);
    rd(0, v2);
    chk("R10 entry not overwritten", v2, 77);

    // R3-R7 random scenarios
    for (int k = 0; k < 40; k++) begin
      int mode = int'($urandom % 5);
      int d = 1 + int'($urandom % 40);
      int n = 20 + int'($urandom % 120);
      string tg;
      lvl = int'($urandom % 11) - 5;
      for (int i = 0; i < n; i++) begin
        if ($urandom % 20 == 0) lvl = int'($urandom % 11) - 5;
        slvl[i] = lvl;
        svals[i] = int'($urandom % 21) - 10;
        svld[i] = ($urandom % 5) != 0;
      end
      case (mode)
        0: tg = "R3"; 1: tg = "R4"; 2: tg = "R5"; 3: tg = "R6"; default: tg = "R7";
      endcase
      run_scn(mode, d, n, tg);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule